// File: doc/BRIEF.md
# Receive Frame Packing FIFO

This block takes received Ethernet frames, one byte per cycle on a valid/last stream, and packs each one into a byte-wide circular store with a fixed wrapper around it. The wrapper is a constant marker word, then a header word that gives the length and status, then the payload. A payload shorter than 60 bytes is extended with zero bytes. A CRC-32 over the padded payload follows, and zero bytes after that bring the record to a 4-byte boundary. A frame is only published to the reader once its whole record has been written.

A host drains stored frames one 32-bit word at a time. The block follows its own read position: first the marker, then the header, then the data words that the header length implies. When the last data word of a record is read, the stored-frame count drops by one. Admission is decided when a frame starts. A frame that would exceed the maximum length is discarded while it arrives. A clear strobe throws away all stored content.

Top module: `rx_pack_fifo`

## Requirements
- R1: A frame is stored only if, on its first byte, `rx_en` is high and at least 1532 bytes of the store are free; otherwise every byte of it is discarded and `frame_cnt` does not change.
- R2: A stored record reads out as the marker word 0x0143414D, the header word, the padded payload, the 4 CRC bytes, then 0 to 3 zero bytes up to a 4-byte boundary. Each word carries its earliest stored byte in bits 7:0 and its latest in bits 31:24.
- R3: Header bits 15:0 hold the padded payload length plus 4, and bits 31:16 hold the success code 0x0001.
- R4: A payload shorter than 60 bytes is extended with zero bytes to exactly 60, and those bytes are both stored and covered by the CRC.
- R5: The CRC is the reflected CRC-32 (polynomial 0xEDB88320), seeded with all ones and inverted at the end. It is stored least significant byte first.
- R6: After the header, exactly ceil(header length / 4) data words belong to the frame. The pop of the last of them lowers `frame_cnt` by one, and the next read returns a marker word.
- R7: A `rd_req` while `frame_cnt` is 0 sees `rd_data` = 0 and removes nothing from the store.
- R8: `cnt_clear` empties the store, sets `frame_cnt` to 0, and returns the read position to the marker word.
- R9: Each committed frame raises `frame_cnt` by one and sets `rx_irq`. `rx_irq` stays set until `irq_ack`.
- R10: A frame with up to 1518 payload bytes is stored. A longer one is discarded completely.
- R11: From the cycle after the last byte of an admitted frame is taken until the record is committed, `in_ready` is low. No byte is taken while `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable, checked at frame start |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Block can take a byte this cycle |
| rd_req | input | 1 | Pop one word from the data register |
| rd_data | output | 32 | Data register value (0 when no frame is stored) |
| cnt_clear | input | 1 | Flush store, frame count and read position |
| frame_cnt | output | CNT_W | Number of complete frames stored |
| irq_ack | input | 1 | Clear the receive interrupt flag |
| rx_irq | output | 1 | Receive interrupt flag |

## Verification
A read-position tracker that is out of step shows up as a misplaced marker word on the very next read. A stale header length changes the cycle in which `frame_cnt` drops, so the next record starts on a data word. A wrong CRC seed or a wrong padding length shows in the CRC word of the first short frame. Faults in the write pointer or in the rewind after an oversized frame corrupt the marker or the payload of the following record the first time it is drained. The checks therefore compare every word of every drained record and read the count after each commit and after each final pop.

// File: rtl/rx_pack_fifo.sv
module rx_pack_fifo #(
  parameter int          DEPTH      = 2048,
  parameter logic [31:0] MAGIC      = 32'h0143414D,
  parameter logic [15:0] OK_CODE    = 16'h0001,
  parameter int          MIN_LEN    = 60,
  parameter int          MAX_LEN    = 1518,
  parameter int          ADMIT_FREE = 1532,
  parameter int          CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             rd_req,
  output logic [31:0]      rd_data,
  input  logic             cnt_clear,
  output logic [CNT_W-1:0] frame_cnt,
  input  logic             irq_ack,
  output logic             rx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int LW = $clog2(MAX_LEN + 8);

  typedef enum logic [2:0] {S_IDLE, S_RECV, S_DROP, S_PAD, S_TAIL} st_t;

  logic [7:0]    mem [DEPTH];
  st_t           state;
  logic [PW-1:0] wr_ptr, base_ptr, rd_ptr;
  logic [LW-1:0] flen, rd_left;
  logic [31:0]   crc;
  logic [1:0]    rd_pos;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  logic [PW-1:0] used;
  logic [PW:0]   free_b;
  logic          admit, take, empty, pop, commit, last_pop, byte_we;
  logic [1:0]    apad;
  logic [15:0]   hdr_len;
  logic [31:0]   fcs, hdr, rd_word;
  logic [AW-1:0] byte_addr, wa, ba, ra;
  logic [7:0]    byte_val;

  assign used     = base_ptr - rd_ptr;
  assign free_b   = (PW+1)'(DEPTH) - {1'b0, used};
  assign admit    = rx_en && (free_b >= (PW+1)'(ADMIT_FREE));
  assign in_ready = (state == S_IDLE) || (state == S_RECV) || (state == S_DROP);
  assign take     = in_valid && in_ready;
  assign empty    = (frame_cnt == '0);
  assign pop      = rd_req && !empty;
  assign last_pop = pop && (rd_pos == 2'd2) && (rd_left == LW'(1));
  assign commit   = (state == S_TAIL) && !cnt_clear;
  assign apad     = 2'(-flen[1:0]);
  assign hdr_len  = 16'(flen) + 16'd4;
  assign hdr      = {OK_CODE, hdr_len};
  assign fcs      = ~crc;
  assign wa       = wr_ptr[AW-1:0];
  assign ba       = base_ptr[AW-1:0];
  assign ra       = rd_ptr[AW-1:0];

  assign byte_we = ((state == S_IDLE) && take && admit) ||
                   ((state == S_RECV) && take && (flen != LW'(MAX_LEN))) ||
                   ((state == S_PAD) && (flen < LW'(MIN_LEN)));
  assign byte_addr = (state == S_IDLE) ? wa + AW'(8) : wa;
  assign byte_val  = (state == S_PAD) ? 8'h00 : in_data;

  assign rd_word = {mem[ra + AW'(3)], mem[ra + AW'(2)], mem[ra + AW'(1)], mem[ra]};
  assign rd_data = empty ? 32'd0 : rd_word;

  always_ff @(posedge clk) begin
    if (byte_we) mem[byte_addr] <= byte_val;
    if (state == S_TAIL) begin
      for (int i = 0; i < 4; i++) begin
        mem[wa + AW'(i)]     <= fcs[8*i +: 8];
        mem[ba + AW'(i)]     <= MAGIC[8*i +: 8];
        mem[ba + AW'(4 + i)] <= hdr[8*i +: 8];
      end
      for (int i = 0; i < 3; i++)
        if (i < int'(apad)) mem[wa + AW'(4 + i)] <= 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; wr_ptr <= '0; base_ptr <= '0; rd_ptr <= '0;
      flen <= '0; crc <= '1; rd_pos <= '0; rd_left <= '0; frame_cnt <= '0;
    end else if (cnt_clear) begin
      wr_ptr <= '0; base_ptr <= '0; rd_ptr <= '0; rd_pos <= '0; rd_left <= '0;
      frame_cnt <= '0;
      if (take && in_last) state <= S_IDLE;
      else if (take || state == S_RECV || state == S_DROP) state <= S_DROP;
      else state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          if (admit) begin
            wr_ptr <= wr_ptr + PW'(9);
            flen   <= LW'(1);
            crc    <= crc_step('1, in_data);
            state  <= in_last ? S_PAD : S_RECV;
          end else state <= in_last ? S_IDLE : S_DROP;
        end
        S_RECV: if (take) begin
          if (flen == LW'(MAX_LEN)) begin
            wr_ptr <= base_ptr;
            state  <= in_last ? S_IDLE : S_DROP;
          end else begin
            wr_ptr <= wr_ptr + PW'(1);
            flen   <= flen + LW'(1);
            crc    <= crc_step(crc, in_data);
            if (in_last) state <= S_PAD;
          end
        end
        S_DROP: if (take && in_last) state <= S_IDLE;
        S_PAD: begin
          if (flen < LW'(MIN_LEN)) begin
            wr_ptr <= wr_ptr + PW'(1);
            flen   <= flen + LW'(1);
            crc    <= crc_step(crc, 8'h00);
          end else state <= S_TAIL;
        end
        S_TAIL: begin
          wr_ptr   <= wr_ptr + PW'(4) + PW'(apad);
          base_ptr <= wr_ptr + PW'(4) + PW'(apad);
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (pop) begin
        rd_ptr <= rd_ptr + PW'(4);
        case (rd_pos)
          2'd0: rd_pos <= 2'd1;
          2'd1: begin
            rd_pos  <= 2'd2;
            rd_left <= LW'(({1'b0, rd_word[15:0]} + 17'd3) >> 2);
          end
          default: begin
            rd_left <= rd_left - LW'(1);
            if (rd_left == LW'(1)) rd_pos <= 2'd0;
          end
        endcase
      end
      frame_cnt <= frame_cnt + CNT_W'(commit) - CNT_W'(last_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_irq <= 1'b0;
    else if (commit) rx_irq <= 1'b1;
    else if (irq_ack) rx_irq <= 1'b0;
  end
endmodule

// File: rtl/rx_pack_fifo_chk.sv
module rx_pack_fifo_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             in_ready,
  input logic             rd_req,
  input logic [31:0]      rd_data,
  input logic             cnt_clear,
  input logic [CNT_W-1:0] frame_cnt,
  input logic             irq_ack,
  input logic             rx_irq
);
  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (frame_cnt == '0));

  // R9
  irq_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_clear) && (frame_cnt == $past(frame_cnt) + CNT_W'(1))) |-> rx_irq);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !irq_ack) |=> rx_irq);

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> ((frame_cnt == $past(frame_cnt)) ||
                    (frame_cnt == $past(frame_cnt) + CNT_W'(1)) ||
                    (frame_cnt == $past(frame_cnt) - CNT_W'(1))));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && frame_cnt == '0 && !cnt_clear) |=> (frame_cnt <= CNT_W'(1)));

  // R11
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_last));
endmodule

bind rx_pack_fifo rx_pack_fifo_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/rx_pack_fifo_tb.sv
module rx_pack_fifo_tb;
  localparam logic [31:0] MAGIC = 32'h0143414D;
  logic clk = 0, rst_n = 0;
  logic rx_en = 0, in_valid = 0, in_last = 0, rd_req = 0, cnt_clear = 0, irq_ack = 0;
  logic [7:0] in_data = 0;
  logic in_ready, rx_irq;
  logic [31:0] rd_data;
  logic [7:0] frame_cnt;

  always #2.5 clk = ~clk;

  rx_pack_fifo u_dut (.*);

  int tests = 0, fails = 0;
  logic [31:0] expq[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  // driver: scoreboard push of the record described by R2..R5
  task automatic push_expected(input logic [7:0] fr[$]);
    logic [7:0] s[$];
    logic [31:0] c = '1;
    int plen;
    s = fr;
    while (s.size() < 60) s.push_back(8'h00);
    plen = s.size();
    foreach (s[i]) c = crc_byte(c, s[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) s.push_back(c[8*i +: 8]);
    while (s.size() % 4 != 0) s.push_back(8'h00);
    expq.push_back(MAGIC);
    expq.push_back({16'h0001, 16'(plen + 4)});
    for (int i = 0; i < s.size(); i += 4) expq.push_back({s[i+3], s[i+2], s[i+1], s[i]});
  endtask

  task automatic send(input int len, input int seed, input bit keep);
    logic [7:0] fr[$];
    for (int i = 0; i < len; i++) fr.push_back(8'((seed + i * 7) ^ (i >> 3)));
    if (keep) push_expected(fr);
    for (int i = 0; i < len; i++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_data = fr[i]; in_last = (i == len - 1);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_word(output logic [31:0] w);
    w = rd_data;
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  // monitor: drain one record, compare against scoreboard
  task automatic drain(input string req);
    logic [31:0] w, e;
    int nw;
    nw = 2 + ((expq[1][15:0] + 3) / 4);
    for (int i = 0; i < nw; i++) begin
      read_word(w);
      e = expq.pop_front();
      chk(w === e, req, w, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [7:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(frame_cnt == 0 && !rx_irq && in_ready && rd_data == 0, "reset", {frame_cnt, 7'd0, rx_irq, in_ready}, 32'h1);

    // R1: disabled receive drops the frame
    send(20, 3, 0);
    chk(frame_cnt == 0, "R1 disabled", frame_cnt, 0);

    rx_en = 1;
    // R4 R5 short frame; R9 count and irq
    send(10, 5, 1);
    chk(frame_cnt == 1, "R9 count", frame_cnt, 1);
    chk(rx_irq == 1, "R9 irq", rx_irq, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk(rx_irq == 0, "R9 ack", rx_irq, 0);
    drain("R2 R3 R4 R5 short");
    chk(frame_cnt == 0, "R6 count down", frame_cnt, 0);

    // R7: empty read
    read_word(w);
    chk(w == 0, "R7 data", w, 0);
    chk(frame_cnt == 0, "R7 count", frame_cnt, 0);
    send(61, 9, 1);
    drain("R2 R7 no pop on empty read");

    // R11: ready low after last byte
    @(negedge clk);
    in_valid = 1; in_data = 8'h44; in_last = 1;
    @(negedge clk);
    in_valid = 0; in_last = 0;
    chk(in_ready == 0, "R11 ready low", in_ready, 0);
    c0 = 8'h44;
    push_expected('{c0});
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk(frame_cnt == 1, "R11 commit", frame_cnt, 1);
    drain("R11 R4 single byte");

    // two frames queued, lengths 64 and 62
    send(64, 21, 1);
    send(62, 33, 1);
    chk(frame_cnt == 2, "R9 two frames", frame_cnt, 2);
    drain("R6 first of two");
    chk(frame_cnt == 1, "R6 after first", frame_cnt, 1);
    drain("R6 second of two");

    // R10 max length kept, then R1 space check rejects next
    send(1518, 77, 1);
    chk(frame_cnt == 1, "R10 max kept", frame_cnt, 1);
    send(30, 2, 0);
    chk(frame_cnt == 1, "R1 no space", frame_cnt, 1);
    drain("R10 max frame");
    send(1519, 8, 0);
    chk(frame_cnt == 0, "R10 oversize dropped", frame_cnt, 0);
    send(70, 44, 1);
    drain("R10 after oversize rewind");

    // R8 flush mid-read
    send(80, 55, 1);
    read_word(w);
    read_word(w);
    read_word(w);
    cnt_clear = 1; @(negedge clk); cnt_clear = 0;
    expq.delete();
    chk(frame_cnt == 0, "R8 count", frame_cnt, 0);
    chk(rd_data == 0, "R8 data", rd_data, 0);
    send(15, 66, 1);
    drain("R8 position reset");
    chk(frame_cnt == 0, "R8 final", frame_cnt, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule